// File: doc/BRIEF.md
# Serial Two-Line Register Loader

This block is a write-only slave on a two-line serial link. An external controller drives a serial clock line and a serial data line. Each word carries one byte of payload and a four-bit register index. The block assembles the word and, when the controller signals a transfer, writes the byte into one of sixteen 8-bit control registers. The register contents leave the block as one flat vector, so the surrounding logic can use the settings directly.

Both lines are asynchronous to the system clock. A configurable synchroniser chain brings them into the system clock domain, and the system clock oversamples them. A bit is taken on each rising edge of the serial clock. The first eight bits are the byte, least significant bit first. The next four bits are the index, also least significant bit first.

A transfer takes the next clock high phase after the twelve bit periods. During that phase the data line must go from low to high. Any other change of the data line while the serial clock is high discards the partial word. When a register is written, a one-cycle strobe marks the cycle and carries the index and the byte.

Top module: `tw_regwrite`

## Requirements
- R1: After reset, all sixteen registers read zero and `wr_stb` is low.
- R2: Data is sampled on each rising edge of `ser_clk`. Bit k of a word (k = 0 first) is byte bit k for k < 8 and index bit k-8 for 8 <= k < 12. The index selects register 0..15, which sits at `regs_o[8*index +: 8]`.
- R3: A write happens when `ser_dat` goes low-to-high while `ser_clk` is high, in the clock high phase that directly follows the twelfth bit period.
- R4: On the cycle the addressed register takes its new value, `wr_stb` is high for exactly one cycle, with `wr_addr` and `wr_data` equal to the index and the byte.
- R5: A transfer attempt after fewer than 12 or more than 12 bit periods writes nothing and clears the bit count. The next correct word is then written normally.
- R6: A falling `ser_dat` edge while `ser_clk` is high discards any partial word. A word sent afterwards is decoded from its own bits only.
- R7: A write changes only the addressed register. All other registers keep their values.
- R8: Changes on `ser_dat` while `ser_clk` is low have no effect other than setting the value taken at the next rising clock edge.
- R9: The registers and the strobe change exactly SYNC_STAGES+1 system clock edges after the line change that causes them (the transfer edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock line from the controller |
| ser_dat | input | 1 | Serial data line from the controller |
| regs_o | output | 128 | Register contents, register i at bits [8*i+7:8*i] |
| wr_stb | output | 1 | One-cycle pulse when a register is written |
| wr_addr | output | 4 | Index of the register written |
| wr_data | output | 8 | Byte written |

## Verification
The bench builds the block with an 8-bit byte, a 4-bit index and a two-stage synchroniser. With these values every one of the sixteen registers can be written and checked, and the reference model's pipeline depth matches the real latency cycle for cycle. The bench holds each line level for several system clocks. This makes legal edges, data glitches while the clock is low, and aborts while the clock is high all take separate sampling cycles, so short words, long words, aborts and glitches can each be checked alone.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_BIT   = 2'd1,
    EV_XFER  = 2'd2,
    EV_ABORT = 2'd3
  } line_ev_e;

  // Classify one oversampled step of the two lines.
  function automatic line_ev_e classify(input logic c, input logic pc,
                                        input logic d, input logic pd);
    if (c && !pc)                 return EV_BIT;
    else if (c && pc && d && !pd) return EV_XFER;
    else if (c && pc && !d && pd) return EV_ABORT;
    else                          return EV_NONE;
  endfunction

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES  = 2,
  parameter int W       = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= {W{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_deser.sv
module tw_deser
  import tw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_c,
  input  logic              line_d,
  output line_ev_e          ev,
  output logic              commit,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data
);
  localparam int WORD_W    = DATA_W + ADDR_W;
  localparam int CNT_ARMED = WORD_W + 1;
  localparam int CNT_MAX   = WORD_W + 2;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  logic              prev_c, prev_d;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] sr;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return (c == CNT_W'(CNT_MAX)) ? c : c + 1'b1;
  endfunction

  assign ev     = classify(line_c, prev_c, line_d, prev_d);
  assign commit = (ev == EV_XFER) && (cnt == CNT_W'(CNT_ARMED));
  assign c_data = sr[DATA_W-1:0];
  assign c_addr = sr[WORD_W-1:DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_c <= 1'b1;
      prev_d <= 1'b1;
      cnt    <= '0;
      sr     <= '0;
    end else begin
      prev_c <= line_c;
      prev_d <= line_d;
      case (ev)
        EV_BIT: begin
          if (cnt < CNT_W'(WORD_W)) sr <= {line_d, sr[WORD_W-1:1]};
          cnt <= next_count(cnt);
        end
        EV_XFER, EV_ABORT: begin
          cnt <= '0;
          sr  <= '0;
        end
        default: ;
      endcase
    end
  end

  // R2: every rising serial clock edge advances the bit count until saturation
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_BIT && cnt < CNT_W'(CNT_MAX)) |=> (cnt == $past(cnt) + 1'b1));

  // R5 / R6: any data change while the clock is high clears the count
  p_clear_after_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_XFER || ev == EV_ABORT) |=> (cnt == '0));

  // R8: with no event, the partial word is left alone
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_NONE) |=> ($stable(cnt) && $stable(sr)));
endmodule

// File: rtl/tw_regbank.sv
module tw_regbank #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  logic [ADDR_W-1:0]            c_addr,
  input  logic [DATA_W-1:0]            c_data,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o,
  output logic                         wr_stb,
  output logic [ADDR_W-1:0]            wr_addr,
  output logic [DATA_W-1:0]            wr_data
);
  localparam int NUM_REGS = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= commit;
      if (commit) begin
        regs[c_addr] <= c_data;
        wr_addr      <= c_addr;
        wr_data      <= c_data;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_o[g*DATA_W +: DATA_W] = regs[g];
  end

  // R4: the strobe lasts a single cycle
  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R4: strobe reports what the register now holds
  p_strobe_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (regs[wr_addr] == wr_data));

  // R7: without a commit no register moves
  p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(regs_o));
endmodule

// File: rtl/tw_regwrite.sv
module tw_regwrite
  import tw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ser_clk,
  input  logic                          ser_dat,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o,
  output logic                          wr_stb,
  output logic [ADDR_W-1:0]             wr_addr,
  output logic [DATA_W-1:0]             wr_data
);
  logic [1:0]        lines_s;
  line_ev_e          ev;
  logic              commit;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;

  tw_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ser_clk, ser_dat}), .q(lines_s));

  tw_deser #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .line_c(lines_s[1]), .line_d(lines_s[0]),
    .ev(ev), .commit(commit), .c_addr(c_addr), .c_data(c_data));

  tw_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit), .c_addr(c_addr), .c_data(c_data),
    .regs_o(regs_o), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

  // R3: a commit only ever comes from a transfer event
  p_commit_from_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (ev == EV_XFER));
endmodule

// File: tb/tw_regwrite_tb.sv
module tw_regwrite_tb;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int SYNC = 2;
  localparam int NR = 1 << AW;
  localparam int HB = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic ser_clk = 1, ser_dat = 1;
  logic [NR*DW-1:0] regs_o;
  logic wr_stb;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int tests = 0, fails = 0;
  bit done = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  tw_regwrite #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .regs_o(regs_o), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

  // behavioural reference model (R9 latency is built into the history depth)
  int hc [SYNC+1];
  int hd [SYNC+1];
  int m_cnt, m_word, m_stb, m_addr, m_data;
  int m_regs [NR];
  int want [NR];
  int stb_seen = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= SYNC; i++) begin hc[i] = 1; hd[i] = 1; end
      m_cnt = 0; m_word = 0; m_stb = 0;
      for (int i = 0; i < NR; i++) m_regs[i] = 0;
    end else begin
      int c, pc, d, pd;
      c = hc[SYNC-1]; pc = hc[SYNC]; d = hd[SYNC-1]; pd = hd[SYNC];
      m_stb = 0;
      if (c == 1 && pc == 0) begin
        if (m_cnt < 12) m_word = m_word | (d << m_cnt);
        if (m_cnt < 14) m_cnt++;
      end else if (c == 1 && pc == 1 && d != pd) begin
        if (d == 1 && m_cnt == 13) begin
          m_addr = (m_word >> 8) & 15;
          m_data = m_word & 255;
          m_regs[m_addr] = m_data;
          m_stb = 1;
        end
        m_cnt = 0; m_word = 0;
      end
      for (int i = SYNC; i > 0; i--) begin hc[i] = hc[i-1]; hd[i] = hd[i-1]; end
      hc[0] = ser_clk; hd[0] = ser_dat;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (wr_stb !== m_stb[0] || (m_stb == 1 && (wr_addr !== m_addr[AW-1:0] || wr_data !== m_data[DW-1:0]))) begin
        fails++;
        $display("FAIL %s/R4/R9 strobe: got stb=%0d a=%0d d=%0h exp stb=%0d a=%0d d=%0h",
                 phase, wr_stb, wr_addr, wr_data, m_stb, m_addr, m_data);
      end
      for (int i = 0; i < NR; i++) begin
        if (regs_o[i*DW +: DW] !== m_regs[i][DW-1:0]) begin
          fails++;
          $display("FAIL %s/R7/R9 reg%0d: got %0h exp %0h", phase, i, regs_o[i*DW +: DW], m_regs[i]);
        end
      end
      if (wr_stb) stb_seen++;
    end
  end

  task automatic put(input logic c, input logic d);
    ser_clk <= c; ser_dat <= d;
    repeat (HB) @(negedge clk);
  endtask

  task automatic send(input int word, input int nbits, input bit xfer, input bit glitch);
    put(0, ser_dat);
    for (int k = 0; k < nbits; k++) begin
      logic b;
      b = (word >> k) & 1;
      if (glitch) begin put(0, ~b); put(0, b); put(0, ~b); end
      put(0, b); put(1, b); put(0, b);
    end
    if (xfer) begin put(0, 0); put(1, 0); put(1, 1); end
    else put(1, 1);
    repeat (HB) @(negedge clk);
  endtask

  task automatic check_reg(input int a, input int exp, input string req);
    tests++;
    if (regs_o[a*DW +: DW] !== exp[DW-1:0]) begin
      fails++;
      $display("FAIL %s reg%0d: got %0h exp %0h", req, a, regs_o[a*DW +: DW], exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < NR; a++) check_reg(a, want[a], req);
  endtask

  task automatic check_strobes(input int exp, input string req);
    tests++;
    if (stb_seen != exp) begin
      fails++;
      $display("FAIL %s strobe count: got %0d exp %0d", req, stb_seen, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < NR; i++) want[i] = 0;
    repeat (5) @(negedge clk);
    // R1: reset state
    check_all("R1");
    tests++;
    if (wr_stb !== 1'b0) begin fails++; $display("FAIL R1 stb: got %0d exp 0", wr_stb); end
    rst_n = 1;
    repeat (4) @(negedge clk);

    phase = "R3";
    send((3 << 8) | 8'hA5, 12, 1, 0); want[3] = 8'hA5;
    check_all("R3"); check_strobes(1, "R4");

    phase = "R2";
    for (int a = 0; a < NR; a++) begin
      int v;
      v = ((a * 37) ^ 8'h5A) & 255;
      send((a << 8) | v, 12, 1, 0); want[a] = v;
    end
    check_all("R2"); check_all("R7"); check_strobes(17, "R4");

    phase = "R5";
    send((5 << 8) | 8'h11, 11, 1, 0);
    check_all("R5"); check_strobes(17, "R5");
    send((6 << 8) | 8'h22 | (1 << 12), 13, 1, 0);
    check_all("R5"); check_strobes(17, "R5");
    send((5 << 8) | 8'hC3, 12, 1, 0); want[5] = 8'hC3;
    check_all("R5"); check_strobes(18, "R5");

    phase = "R6";
    send(8'h3F, 6, 0, 0);
    put(1, 0); put(1, 1);
    check_all("R6");
    send((9 << 8) | 8'h81, 12, 1, 0); want[9] = 8'h81;
    check_all("R6"); check_strobes(19, "R6");

    phase = "R8";
    send((12 << 8) | 8'h6E, 12, 1, 1); want[12] = 8'h6E;
    check_all("R8"); check_strobes(20, "R8");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule